// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Output Writes and a Shared Interrupt

This block gives software control over sixteen general-purpose pins through a small 32-bit register interface. A direction register chooses, pin by pin, whether the pad is driven. The output register accepts writes that carry a per-pin change mask in the upper half-word, so one pin can be set or cleared in a single bus write without first reading the register. Pin levels pass through a two-stage synchronizer before they reach the readback register or the interrupt logic.

The low eight pins each drive their own active-high, level-sensitive interrupt output. The high eight pins are each gated by an enable bit and then ORed onto one shared request line. A control register holds a clock enable and a soft reset. The bring-up sequence is to write 3 (reset held with the clock running) and then 1 (reset released). Writing 2 parks the block in its low-power, disabled state, which is also the state it comes out of hardware reset in.

Top module: `gpio_bank16`

## Requirements
- R1: After `rst_n` is held low for a rising edge, the direction, output and interrupt-enable registers read 0, `pin_oe` and `pin_out` are 0, and the control register reads 2 (soft reset set, clock off).
- R2: Offset 0x00 is the direction register (bits 15:0). A 1 in bit n drives `pin_oe[n]` high, making pin n an output. A 0 makes it an input. A write is visible on the port and in the readback from the next cycle.
- R3: Offset 0x08 is the output register. A write changes bit n only when bit n+16 of the written word is 1, and then bit n takes written bit n. Bits whose mask bit is 0 keep their value. `pin_out` shows the register.
- R4: Offset 0x0C reads the synchronized pin levels in bits 15:0. A level applied to `pin_in` before a rising edge appears in the readback after the second rising edge and not after the first.
- R5: `irq_pin[n]` for n = 0..7 is the synchronized level of pin n, active high.
- R6: Offset 0x10 holds one interrupt-enable bit per shared pin, in bits 15:8, and bits 7:0 read 0. `irq_shared` is high exactly when some pin n in 8..15 has a synchronized level of 1 and its enable bit n is 1.
- R7: Offset 0x14 is the control register: bit 0 is the clock enable and bit 1 is the soft reset. While bit 1 is 1, the direction, output and enable registers are cleared and held at 0, and writes to them are ignored. The control register itself keeps the written value.
- R8: While control bit 0 is 0, the pin synchronizer holds its value and writes to every register except the control register are ignored.
- R9: Offsets other than the five listed read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Raw pin levels from the pads |
| pin_out | output | 16 | Output register value to the pads |
| pin_oe | output | 16 | Per-pin output enable (direction register) |
| irq_pin | output | 8 | Dedicated interrupts for pins 0..7 |
| irq_shared | output | 1 | Gated OR of pins 8..15 |

## Verification
The assertions assume that a write lasts exactly one cycle with a stable address and data, and that a register changes only through its own write or through a reset. The synchronizer property also assumes `pin_in` is sampled once per edge with no meaning given to glitches. The bench drives all inputs on the falling edge, so pins and bus signals are steady at every rising edge. It also changes pins only after the previous level has had two edges to settle, except in the one step that probes the first-edge latency on purpose.

// File: rtl/gpio_bank_pkg.sv
// Package: register offsets, register select type and the address decoder
// shared by the GPIO bank modules. Assumes byte offsets in an 8-bit space.
package gpio_bank_pkg;

    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_OUT  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_LVL  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h14;

    // Reset value of the control word: soft reset set, clock off.
    localparam logic [1:0] CTRL_RESET = 2'b10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_OUT,
        SEL_LVL,
        SEL_IEN,
        SEL_CTRL
    } reg_sel_e;

    // Map a byte offset to the register it selects.
    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        unique case (a)
            OFS_DIR:  return SEL_DIR;
            OFS_OUT:  return SEL_OUT;
            OFS_LVL:  return SEL_LVL;
            OFS_IEN:  return SEL_IEN;
            OFS_CTRL: return SEL_CTRL;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
// Module: two-flop level synchronizer with a hold enable.
// Assumes: d is asynchronous to clk. While en is low both stages keep their
// contents, which freezes the sampled pin levels when the clock is gated off.
module gpio_bank_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pin levels through two stages while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else if (en) begin
            stage1_q <= d;
            stage2_q <= stage1_q;
        end
    end

    assign q = stage2_q;

    AST_SYNC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R8

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |=> (q == $past(d, 2))); // R4

endmodule

// File: rtl/gpio_bank_irq.sv
// Module: interrupt gating. The low pins pass straight through as dedicated
// requests. Each high pin is ANDed with its enable and the results are ORed.
// Assumes: lvl is already synchronized to clk. Pure combinational logic.
module gpio_bank_irq #(
    parameter int unsigned NPINS     = 16,
    parameter int unsigned SHARED_LO = 8,
    localparam int unsigned NSH      = NPINS - SHARED_LO
) (
    input  logic [NPINS-1:0]     lvl,
    input  logic [NSH-1:0]       ien,
    output logic [SHARED_LO-1:0] irq_pin,
    output logic                 irq_shared
);

    logic [NSH-1:0] gated;

    // One AND gate per shared pin.
    for (genvar k = 0; k < NSH; k++) begin : g_gate
        assign gated[k] = lvl[SHARED_LO+k] & ien[k];
    end

    // Dedicated requests follow the low pin levels. Shared request is the OR.
    always_comb begin
        irq_pin    = lvl[SHARED_LO-1:0];
        irq_shared = |gated;
    end

endmodule

// File: rtl/gpio_bank_regs.sv
// Module: register file and bus decode of the GPIO bank.
// Assumes: a write lasts one cycle and reads are combinational. The control
// word is always writable. The other registers accept writes only when the
// clock enable is set and the soft reset is clear.
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS     = 16,
    parameter int unsigned SHARED_LO = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned NSH      = NPINS - SHARED_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPINS-1:0]  lvl,
    output logic [DATA_W-1:0] rdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NSH-1:0]    ien_q,
    output logic              clk_en,
    output logic              blk_rst
);

    reg_sel_e         sel;
    logic [1:0]       ctrl_q;
    logic             wr_ok;
    logic [NPINS-1:0] mask;

    always_comb begin
        sel     = decode_ofs(addr);
        clk_en  = ctrl_q[0];
        blk_rst = ctrl_q[1];
        wr_ok   = wen && clk_en && !blk_rst;
        mask    = wdata[2*NPINS-1:NPINS];
    end

    // Control word: writable at all times, leaves hardware reset parked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (wen && sel == SEL_CTRL)
            ctrl_q <= wdata[1:0];
    end

    // Direction register: a 1 makes a pin an output.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_rst)
            dir_q <= '0;
        else if (wr_ok && sel == SEL_DIR)
            dir_q <= wdata[NPINS-1:0];
    end

    // Output register: only the bits selected by the upper-half mask change.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_rst)
            out_q <= '0;
        else if (wr_ok && sel == SEL_OUT)
            out_q <= (out_q & ~mask) | (wdata[NPINS-1:0] & mask);
    end

    // Interrupt enables for the shared pins, taken from their own bit positions.
    always_ff @(posedge clk) begin
        if (!rst_n || blk_rst)
            ien_q <= '0;
        else if (wr_ok && sel == SEL_IEN)
            ien_q <= wdata[NPINS-1:SHARED_LO];
    end

    // Read multiplexer. Unmapped offsets read as zero.
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_DIR:  rdata[NPINS-1:0]         = dir_q;
            SEL_OUT:  rdata[NPINS-1:0]         = out_q;
            SEL_LVL:  rdata[NPINS-1:0]         = lvl;
            SEL_IEN:  rdata[NPINS-1:SHARED_LO] = ien_q;
            SEL_CTRL: rdata[1:0]               = ctrl_q;
            default:  rdata                    = '0;
        endcase
    end

    AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        blk_rst |=> (dir_q == '0 && out_q == '0 && ien_q == '0)); // R7

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !blk_rst) |=> ($stable(dir_q) && $stable(out_q) && $stable(ien_q))); // R8

    AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && sel == SEL_OUT && clk_en && !blk_rst)
        |=> (((out_q ^ $past(out_q)) & ~$past(mask)) == '0)); // R3

    AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wen && sel == SEL_NONE && !blk_rst)
        |=> ($stable(dir_q) && $stable(out_q) && $stable(ien_q) && $stable(ctrl_q))); // R9

endmodule

// File: rtl/gpio_bank16.sv
// Module: top of the sixteen-pin GPIO bank. Ties the synchronizer, register
// file and interrupt gating together. Assumes pins are asynchronous inputs
// and the bus master holds each write for exactly one cycle.
module gpio_bank16
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS     = 16,
    parameter int unsigned SHARED_LO = 8,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned NSH      = NPINS - SHARED_LO
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wen,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [SHARED_LO-1:0] irq_pin,
    output logic                 irq_shared
);

    logic [NPINS-1:0] lvl;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;
    logic [NSH-1:0]   ien_q;
    logic             clk_en;
    logic             blk_rst;

    gpio_bank_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en),
        .d     (pin_in),
        .q     (lvl)
    );

    gpio_bank_regs #(
        .NPINS     (NPINS),
        .SHARED_LO (SHARED_LO),
        .DATA_W    (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wen     (bus_wen),
        .wdata   (bus_wdata),
        .lvl     (lvl),
        .rdata   (bus_rdata),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .ien_q   (ien_q),
        .clk_en  (clk_en),
        .blk_rst (blk_rst)
    );

    gpio_bank_irq #(
        .NPINS     (NPINS),
        .SHARED_LO (SHARED_LO)
    ) u_irq (
        .lvl        (lvl),
        .ien        (ien_q),
        .irq_pin    (irq_pin),
        .irq_shared (irq_shared)
    );

    // Pads see the registers directly.
    always_comb begin
        pin_out = out_q;
        pin_oe  = dir_q;
    end

    AST_SHARED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq_shared); // R6

    AST_OE_CLEARED_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        blk_rst |=> (pin_oe == '0)); // R7

endmodule

// File: tb/tb_gpio_bank16.sv
// Scoreboard bench: the driver pushes expected items and a monitor process
// pops them and compares against the outputs, sampled on the falling edge.
module tb_gpio_bank16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [7:0]  irq_pin;
    logic        irq_shared;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef enum int {K_RDATA, K_POUT, K_POE, K_IRQP, K_IRQS} kind_e;
    typedef struct {
        kind_e       kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  sample_ev;

    always #2.5 clk = ~clk;

    gpio_bank16 dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wen    (bus_wen),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe),
        .irq_pin    (irq_pin),
        .irq_shared (irq_shared)
    );

    // Monitor: pop each expected item and compare against the live output.
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_RDATA: act = bus_rdata;
                    K_POUT:  act = {16'h0, pin_out};
                    K_POE:   act = {16'h0, pin_oe};
                    K_IRQP:  act = {24'h0, irq_pin};
                    default: act = {31'h0, irq_shared};
                endcase
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Driver: one-cycle write launched from the falling edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    // Queue an expectation and hand it to the monitor.
    task automatic expect_out(input kind_e k, input logic [7:0] a,
                              input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        #0.5;
        it.kind = k;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #0.5;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        expect_out(K_RDATA, a, e, tag);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Apply pin levels and wait for both synchronizer stages.
    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        step(2);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        expect_rd(8'h00, 32'h0, "R1 dir after reset");
        expect_rd(8'h08, 32'h0, "R1 out after reset");
        expect_rd(8'h10, 32'h0, "R1 ien after reset");
        expect_rd(8'h14, 32'h2, "R1 ctrl after reset");
        expect_out(K_POE, 8'h00, 32'h0, "R1 pin_oe after reset");
        expect_out(K_POUT, 8'h00, 32'h0, "R1 pin_out after reset");

        // R7 bring-up sequence: 3 then 1
        bus_write(8'h14, 32'h3);
        bus_write(8'h14, 32'h1);
        expect_rd(8'h14, 32'h1, "R7 ctrl running");

        // R2 direction
        bus_write(8'h00, 32'h0000_00F0);
        expect_rd(8'h00, 32'h0000_00F0, "R2 dir readback");
        expect_out(K_POE, 8'h00, 32'h0000_00F0, "R2 pin_oe");

        // R3 masked output writes
        bus_write(8'h08, 32'hFFFF_A5A5);
        expect_out(K_POUT, 8'h00, 32'h0000_A5A5, "R3 full-mask write");
        bus_write(8'h08, 32'h0003_0000);
        expect_out(K_POUT, 8'h00, 32'h0000_A5A4, "R3 clear bits 1:0");
        bus_write(8'h08, 32'h8000_00FF);
        expect_out(K_POUT, 8'h00, 32'h0000_25A4, "R3 clear bit15 unmasked data ignored");
        bus_write(8'h08, 32'h0010_0010);
        expect_rd(8'h08, 32'h0000_25B4, "R3 set bit4 readback");

        // R4 / R5 pin levels and dedicated interrupts
        set_pins(16'h1234);
        expect_rd(8'h0C, 32'h0000_1234, "R4 level readback");
        expect_out(K_IRQP, 8'h00, 32'h34, "R5 dedicated irq");
        @(negedge clk);
        pin_in = 16'h00FF;
        step(1);
        expect_rd(8'h0C, 32'h0000_1234, "R4 not visible after one edge");
        step(1);
        expect_rd(8'h0C, 32'h0000_00FF, "R4 visible after two edges");
        expect_out(K_IRQP, 8'h00, 32'hFF, "R5 dedicated irq all high");

        // R6 shared interrupt gating
        set_pins(16'h0F00);
        expect_out(K_IRQP, 8'h00, 32'h00, "R5 dedicated irq low");
        expect_out(K_IRQS, 8'h00, 32'h0, "R6 shared low with no enables");
        bus_write(8'h10, 32'h0000_0800);
        expect_out(K_IRQS, 8'h00, 32'h1, "R6 shared high pin11 enabled");
        expect_rd(8'h10, 32'h0000_0800, "R6 ien readback");
        bus_write(8'h10, 32'h0000_F0FF);
        expect_rd(8'h10, 32'h0000_F000, "R6 low enable bits read zero");
        expect_out(K_IRQS, 8'h00, 32'h0, "R6 shared low enables miss pins");
        set_pins(16'h8000);
        expect_out(K_IRQS, 8'h00, 32'h1, "R6 shared high pin15");

        // R9 unmapped offset
        bus_write(8'h04, 32'hFFFF_FFFF);
        expect_rd(8'h04, 32'h0, "R9 unmapped reads zero");
        expect_rd(8'h00, 32'h0000_00F0, "R9 dir untouched");
        expect_out(K_POUT, 8'h00, 32'h0000_25B4, "R9 out untouched");

        // R8 clock off: writes ignored, sampling frozen
        bus_write(8'h14, 32'h0);
        bus_write(8'h00, 32'h0000_FFFF);
        expect_rd(8'h00, 32'h0000_00F0, "R8 dir write ignored");
        bus_write(8'h08, 32'hFFFF_0000);
        expect_out(K_POUT, 8'h00, 32'h0000_25B4, "R8 out write ignored");
        set_pins(16'h0001);
        step(1);
        expect_rd(8'h0C, 32'h0000_8000, "R8 levels frozen");
        expect_rd(8'h14, 32'h0, "R8 ctrl readback");
        bus_write(8'h14, 32'h1);
        step(2);
        expect_rd(8'h0C, 32'h0000_0001, "R8 sampling resumes");

        // R7 soft reset clears and holds registers
        bus_write(8'h14, 32'h3);
        step(1);
        expect_rd(8'h00, 32'h0, "R7 dir cleared");
        expect_rd(8'h08, 32'h0, "R7 out cleared");
        expect_rd(8'h10, 32'h0, "R7 ien cleared");
        bus_write(8'h00, 32'h0000_FFFF);
        expect_rd(8'h00, 32'h0, "R7 dir write ignored in reset");
        expect_rd(8'h14, 32'h3, "R7 ctrl keeps value");
        bus_write(8'h14, 32'h1);
        bus_write(8'h00, 32'h0000_0101);
        expect_out(K_POE, 8'h00, 32'h0000_0101, "R7 writes work after release");

        step(2);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule